// File: doc/BRIEF.md
# Indirect Redirection Table Register Window

This block holds a table of 64-bit interrupt redirection entries and gives a bus master access to it through two 32-bit registers. The first is a select register that holds an 8-bit index. The second is a data window, and it reaches whatever the current index points at. Software writes an index into the select register first. It then reads or writes the window. Through the window, software can reach an identity register, a read-only version word, a reserved slot that always reads zero, or either half of any table entry.

The bus side is a plain write strobe with an address and write data. Read data is returned combinationally from the address and the current index. The block decodes only the low byte of the address, so the window pair repeats across the rest of the address range.

Each time a table entry is written, the block sends a one-cycle "table changed" pulse to the interrupt service logic, which must then re-evaluate pending requests. At reset every entry starts masked.

Top module: `rtw_top`

## Requirements
- R1: Only address bits 7:0 are decoded. Offset 0x00 is the select register: a write stores bits 7:0 of the write data, and a read returns the index zero-extended to 32 bits.
- R2: A read at any offset other than 0x00 and 0x10 returns 0. A write at such an offset changes neither the index, the identity, nor any entry.
- R3: With index 0x00, the window reads the identity in bits 31:24 with all other bits zero. A write with index 0x00 loads bits 31:24 of the write data as the new identity.
- R4: With index 0x01, the window reads 0x00170011: version code 0x11 in bits 7:0 and the highest entry number (NUM_ENT-1 = 23) in bits 23:16. Writes with this index have no effect.
- R5: With index 0x02, the window always reads 0, and writes with this index have no effect.
- R6: Index 0x10+2n reaches bits 31:0 of entry n, and index 0x11+2n reaches bits 63:32. A write changes only the addressed half.
- R7: An index of 0x03 to 0x0F, or an index that maps to an entry number of NUM_ENT or above (0x40 to 0xFF), reads 0 and ignores writes.
- R8: After reset every entry holds 0x0000_0000_0001_0000 (only the mask bit, bit 16, set), and both the index and the identity are 0.
- R9: `tblChanged` is high for exactly one cycle, in the cycle after each write strobe that lands on an entry half. It stays low after any other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (12) | Byte address; only bits 7:0 decoded |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data |
| tblChanged | output | 1 | One-cycle pulse after an entry write |

## Verification
The in-RTL assertions cover five properties on every cycle:
- the pulse follows each entry write, and only an entry write;
- the identity and the index hold their values unless their own strobe fires;
- a write to one half of an entry leaves the other half unchanged;
- writes through indices 0x01 and 0x02 produce no storage strobe;
- offsets other than the pair read zero.

Several things only the directed scenarios can show:
- the exact read values (reset contents, version word, identity placement);
- address aliasing above bit 7;
- whether a write aimed at an out-of-range or reserved index disturbed any visible register.

// File: rtl/rtw_pkg.sv
package rtw_pkg;

  typedef struct packed {
    logic       selWr;
    logic       idWr;
    logic       entWr;
    logic       entHi;
    logic [7:0] entNum;
  } winStrobe_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_SEL,
    RD_ID,
    RD_VER,
    RD_ENT
  } rdSrc_t;

endpackage

// File: rtl/rtw_ctrl.sv
module rtw_ctrl
  import rtw_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_ENT = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        selReg,
  output winStrobe_t        strb,
  output rdSrc_t            rdSrc
);

  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_WIN  = 8'h10;
  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_ENT0 = 8'h10;

  logic       hitSel;
  logic       hitWin;
  logic [7:0] entOff;
  logic [7:0] entNum;
  logic       entValid;

  assign hitSel   = (busAddr[7:0] == OFF_SEL);
  assign hitWin   = (busAddr[7:0] == OFF_WIN);
  assign entOff   = selReg - IDX_ENT0;
  assign entNum   = {1'b0, entOff[7:1]};
  assign entValid = (selReg >= IDX_ENT0) && (int'(entNum) < NUM_ENT);

  always_comb begin
    strb.selWr  = busWrEn && hitSel;
    strb.idWr   = busWrEn && hitWin && (selReg == IDX_ID);
    strb.entWr  = busWrEn && hitWin && entValid;
    strb.entHi  = entOff[0];
    strb.entNum = entNum;
  end

  always_comb begin
    rdSrc = RD_ZERO;
    if (hitSel) begin
      rdSrc = RD_SEL;
    end else if (hitWin) begin
      if (selReg == IDX_ID)       rdSrc = RD_ID;
      else if (selReg == IDX_VER) rdSrc = RD_VER;
      else if (entValid)          rdSrc = RD_ENT;
    end
  end

  AST_RO_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && hitWin && (selReg == 8'h01 || selReg == 8'h02))
      |-> !(strb.idWr || strb.entWr || strb.selWr)); // R4 R5

endmodule

// File: rtl/rtw_regs.sv
module rtw_regs
  import rtw_pkg::*;
#(
  parameter int         NUM_ENT  = 24,
  parameter int         MASK_BIT = 16,
  parameter logic [7:0] VER_CODE = 8'h11
) (
  input  logic        clk,
  input  logic        rstN,
  input  winStrobe_t  strb,
  input  rdSrc_t      rdSrc,
  input  logic [31:0] wrData,
  output logic [7:0]  selReg,
  output logic [31:0] rdData,
  output logic        chgPulse
);

  localparam int          HALF_W  = 32;
  localparam int          ENT_W   = 2 * HALF_W;
  localparam int          ENT_IW  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << MASK_BIT;
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENT - 1), 8'h00, VER_CODE};

  logic [7:0]       idReg;
  logic [ENT_W-1:0] tbl [NUM_ENT];
  logic [ENT_W-1:0] entRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg   <= '0;
      idReg    <= '0;
      chgPulse <= 1'b0;
    end else begin
      if (strb.selWr) selReg <= wrData[7:0];
      if (strb.idWr)  idReg  <= wrData[31:24];
      chgPulse <= strb.entWr;
    end
  end

  for (genvar n = 0; n < NUM_ENT; n++) begin : g_ent
    logic hitEnt;
    assign hitEnt = strb.entWr && (int'(strb.entNum) == n);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tbl[n] <= ENT_RST;
      end else if (hitEnt) begin
        if (strb.entHi) tbl[n][ENT_W-1:HALF_W] <= wrData;
        else            tbl[n][HALF_W-1:0]     <= wrData;
      end
    end

    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rstN)
      (hitEnt && !strb.entHi) |=> $stable(tbl[n][ENT_W-1:HALF_W])); // R6
    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rstN)
      (hitEnt && strb.entHi) |=> $stable(tbl[n][HALF_W-1:0])); // R6
  end

  assign entRd = tbl[strb.entNum[ENT_IW-1:0]];

  always_comb begin
    unique case (rdSrc)
      RD_SEL:  rdData = {24'h0, selReg};
      RD_ID:   rdData = {idReg, 24'h0};
      RD_VER:  rdData = VER_WORD;
      RD_ENT:  rdData = strb.entHi ? entRd[ENT_W-1:HALF_W] : entRd[HALF_W-1:0];
      default: rdData = '0;
    endcase
  end

  AST_CHG_AFTER_WR: assert property (@(posedge clk) disable iff (!rstN)
    strb.entWr |=> chgPulse); // R9
  AST_CHG_ONLY_WR: assert property (@(posedge clk) disable iff (!rstN)
    chgPulse |-> $past(strb.entWr)); // R9
  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.idWr |=> $stable(idReg)); // R3
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.selWr |=> $stable(selReg)); // R1

endmodule

// File: rtl/rtw_top.sv
module rtw_top
  import rtw_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_ENT = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              tblChanged
);

  winStrobe_t strb;
  rdSrc_t     rdSrc;
  logic [7:0] selReg;

  rtw_ctrl #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .selReg  (selReg),
    .strb    (strb),
    .rdSrc   (rdSrc)
  );

  rtw_regs #(.NUM_ENT(NUM_ENT)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdSrc    (rdSrc),
    .wrData   (busWrData),
    .selReg   (selReg),
    .rdData   (busRdData),
    .chgPulse (tblChanged)
  );

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[7:0] != 8'h00 && busAddr[7:0] != 8'h10) |-> busRdData == 32'h0); // R2

endmodule

// File: tb/sim_rtw_top.sv
module sim_rtw_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        tblChanged;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rtw_top u0 (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .tblChanged (tblChanged)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns {pulse in cycle after strobe, pulse one cycle later}
  task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic [1:0] pw);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    pw[1] = tblChanged;
    @(negedge clk);
    pw[0] = tblChanged;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic winRead(input logic [7:0] idx, output logic [31:0] d);
    logic [1:0] pw;
    wr(12'h000, {24'h0, idx}, pw);
    rd(12'h010, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h000, d);      chk("R8 index after reset", d, 32'h0);
    winRead(8'h00, d);   chk("R8 id after reset", d, 32'h0);
    winRead(8'h10, d);   chk("R8 entry0 low reset", d, 32'h0001_0000);
    winRead(8'h11, d);   chk("R8 entry0 high reset", d, 32'h0);
    winRead(8'h3E, d);   chk("R8 entry23 low reset", d, 32'h0001_0000);
  endtask

  task automatic t_select;
    logic [31:0] d; logic [1:0] pw;
    wr(12'h000, 32'hABCD_EF5A, pw);
    rd(12'h000, d);      chk("R1 index keeps low byte", d, 32'h5A);
    chk("R9 no pulse on select write", {30'h0, pw}, 32'h0);
    wr(12'h700, 32'h0000_0012, pw);
    rd(12'hF00, d);      chk("R1 high address bits ignored", d, 32'h12);
  endtask

  task automatic t_id;
    logic [31:0] d; logic [1:0] pw;
    wr(12'h000, 32'h0, pw);
    wr(12'h010, 32'hA512_3456, pw);
    rd(12'h010, d);      chk("R3 id in top byte", d, 32'hA500_0000);
    chk("R9 no pulse on id write", {30'h0, pw}, 32'h0);
  endtask

  task automatic t_version;
    logic [31:0] d; logic [1:0] pw;
    winRead(8'h01, d);   chk("R4 version word", d, 32'h0017_0011);
    wr(12'h010, 32'hFFFF_FFFF, pw);
    rd(12'h010, d);      chk("R4 version unchanged by write", d, 32'h0017_0011);
    chk("R9 no pulse on version write", {30'h0, pw}, 32'h0);
  endtask

  task automatic t_reserved;
    logic [31:0] d; logic [1:0] pw;
    winRead(8'h02, d);   chk("R5 reserved reads zero", d, 32'h0);
    wr(12'h010, 32'hFFFF_FFFF, pw);
    rd(12'h010, d);      chk("R5 reserved after write", d, 32'h0);
    winRead(8'h00, d);   chk("R5 id untouched", d, 32'hA500_0000);
  endtask

  task automatic t_entry;
    logic [31:0] d; logic [1:0] pw;
    wr(12'h000, 32'h1A, pw);
    wr(12'h010, 32'h1234_ABCD, pw);
    chk("R9 pulse pattern low write", {30'h0, pw}, 32'h2);
    rd(12'h010, d);      chk("R6 entry5 low readback", d, 32'h1234_ABCD);
    winRead(8'h1B, d);   chk("R6 entry5 high intact", d, 32'h0);
    wr(12'h010, 32'hFE00_0000, pw);
    chk("R9 pulse pattern high write", {30'h0, pw}, 32'h2);
    rd(12'h010, d);      chk("R6 entry5 high readback", d, 32'hFE00_0000);
    winRead(8'h1A, d);   chk("R6 entry5 low intact", d, 32'h1234_ABCD);
    winRead(8'h18, d);   chk("R6 entry4 low untouched", d, 32'h0001_0000);
    wr(12'h000, 32'h3F, pw);
    wr(12'h010, 32'h0C0F_FEE0, pw);
    chk("R9 pulse on entry23", {30'h0, pw}, 32'h2);
    rd(12'h010, d);      chk("R6 entry23 high", d, 32'h0C0F_FEE0);
    winRead(8'h3E, d);   chk("R6 entry23 low intact", d, 32'h0001_0000);
  endtask

  task automatic t_outrange;
    logic [31:0] d; logic [1:0] pw;
    foreach (d[i]) begin end
    for (int k = 0; k < 3; k++) begin
      logic [7:0] idx;
      idx = (k == 0) ? 8'h40 : (k == 1) ? 8'h05 : 8'hFF;
      wr(12'h000, {24'h0, idx}, pw);
      wr(12'h010, 32'h5555_AAAA, pw);
      chk("R7 no pulse out of range", {30'h0, pw}, 32'h0);
      rd(12'h010, d);    chk("R7 out of range reads zero", d, 32'h0);
    end
    winRead(8'h10, d);   chk("R7 entry0 low untouched", d, 32'h0001_0000);
    winRead(8'h11, d);   chk("R7 entry0 high untouched", d, 32'h0);
    winRead(8'h00, d);   chk("R7 id untouched", d, 32'hA500_0000);
  endtask

  task automatic t_offsets;
    logic [31:0] d; logic [1:0] pw;
    wr(12'h000, 32'h10, pw);
    rd(12'h004, d);      chk("R2 offset 0x04 reads zero", d, 32'h0);
    rd(12'h0FF, d);      chk("R2 offset 0xFF reads zero", d, 32'h0);
    wr(12'h014, 32'h7777_7777, pw);
    wr(12'h008, 32'h0000_0033, pw);
    chk("R2 no pulse at stray offset", {30'h0, pw}, 32'h0);
    rd(12'h000, d);      chk("R2 index untouched", d, 32'h10);
    rd(12'h010, d);      chk("R2 entry0 untouched", d, 32'h0001_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset;
    t_select;
    t_id;
    t_version;
    t_reserved;
    t_entry;
    t_outrange;
    t_offsets;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule